// File: doc/BRIEF.md
# Bang-Bang Clock Lock Controller

This block is the digital half of a crystal-oscillator phase-locked loop that follows a bunch reference clock of about 40.08 MHz. The oscillator's frequency is set by two values. A 6-bit coarse code moves the frequency monotonically over the tuning range. A fine control word adjusts the frequency between coarse steps. The analog oscillator, the frequency counter and the phase detector sit outside the block. The block receives only their one-bit decisions.

When `cal_mode_i` is high at start-up, the controller first runs a successive-approximation search of the coarse code. Each step spends one counting window of `CAL_WIN` cycles and takes one bit decision from the frequency comparison, so the search ends after six windows. When `cal_mode_i` is low, the search is skipped, the coarse code stays at mid-scale and tracking begins at once. Tracking is a bang-bang loop: an early decision moves the fine word down by one and a late decision moves it up by one. The allowed tuning span is narrow, so the fine word saturates at its ends. A push against either end means the loop has lost its range. That event clears the lock flag and, in calibrating mode, restarts the coarse search.

The lock flag rises after `LOCK_WINS` consecutive tracking windows of `TRACK_WIN` cycles that each saw both an early and a late decision. Seeing both decisions in one window means the loop is dithering around the reference phase.

Top module: `clk_lock_ctrl`

## Requirements
- R1: While `rst_ni` is low, `coarse_o` is 32 (mid-scale), `fine_o` is 2^(FINE_W-1) (mid-scale) and `locked_o` is 0.
- R2: With `cal_mode_i`=1 at the first clock after reset, the coarse code is found by binary search from the most significant bit down.
  - The search starts at 32.
  - At the end of each `CAL_WIN`-cycle window, the bit under test is cleared if `freq_fast_i`=1 (oscillator above reference) and kept otherwise, and the next lower bit is set.
  - After 6 windows (at the 6*CAL_WIN+1-th clock after reset release) the code equals the largest code for which the comparator reports not fast.
- R3: With `cal_mode_i`=0, no search runs. `coarse_o` stays 32 and early/late decisions act from the second clock after reset release.
- R4: In tracking, early alone decrements `fine_o` by 1, late alone increments it by 1, and both or neither leave it unchanged, all at the next clock.
- R5: `fine_o` saturates: early at 0 leaves 0, and late at 2^FINE_W-1 leaves 2^FINE_W-1.
- R6: Early/late inputs are ignored during calibration, and `fine_o` is held at mid-scale there.
- R7: `locked_o` rises after `LOCK_WINS` consecutive tracking windows that each contain at least one early and one late decision and no saturation push. A window lacking either decision restarts the count. Once high, `locked_o` stays high until a saturation push.
- R8: A saturation push (early at 0 or late at full scale) clears `locked_o` and the window count at that clock.
- R9: In calibrating mode, a saturation push restarts the search. At the next clock `coarse_o` returns to 32 and `fine_o` returns to mid-scale, and a full 6-window search follows.
- R10: `coarse_o` does not change while tracking, except on the restart of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-derived clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cal_mode_i | input | 1 | 1: calibrate coarse code before tracking; 0: track directly |
| freq_fast_i | input | 1 | Frequency comparison: 1 when oscillator count exceeds reference count |
| early_i | input | 1 | Phase detector says oscillator edge is early (one decision per cycle) |
| late_i | input | 1 | Phase detector says oscillator edge is late |
| coarse_o | output | CODE_W | Coarse frequency select code |
| fine_o | output | FINE_W | Fine control word |
| locked_o | output | 1 | Loop is dithering around phase lock |

## Verification
A wrong search state shows up in `coarse_o` at the end of the first window, because the half-way code is already 16 or 48 there. A wrong final code shows up at the clock where tracking takes over. A fine-word fault shows up one clock after the decision that exposes it, since every early/late input is compared against a saturating reference count. A lock-streak fault changes the clock at which `locked_o` rises: the flag must stay low through LOCK_WINS-1 dithering windows and must be high two windows later. A missed restart leaves `coarse_o` away from 32 on the clock after a saturation push.

// File: rtl/clk_lock_pkg.sv
package clk_lock_pkg;
  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_CAL   = 2'd1,
    ST_TRACK = 2'd2
  } lock_state_e;
endpackage

// File: rtl/win_timer.sv
module win_timer #(
  parameter int WIN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              fast_i,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o
);
  localparam int BW = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [BW-1:0] TOP = BW'(CODE_W - 1);

  logic [CODE_W-1:0] code_q, code_n;
  logic [BW-1:0]     bit_q, bit_n;

  always_comb begin
    code_n = code_q;
    bit_n  = bit_q;
    if (start_i) begin
      code_n = MID;
      bit_n  = TOP;
    end else if (step_i) begin
      if (fast_i) code_n[bit_q] = 1'b0;
      if (bit_q != '0) begin
        bit_n = bit_q - 1'b1;
        code_n[bit_n] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= MID;
      bit_q  <= TOP;
    end else begin
      code_q <= code_n;
      bit_q  <= bit_n;
    end
  end

  assign code_o = code_q;
  assign done_o = step_i && !start_i && (bit_q == '0);
endmodule

// File: rtl/fine_track.sv
module fine_track #(
  parameter int FINE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              en_i,
  input  logic              early_i,
  input  logic              late_i,
  output logic [FINE_W-1:0] fine_o,
  output logic              sat_o
);
  localparam logic [FINE_W-1:0] MID = FINE_W'(1) << (FINE_W - 1);
  localparam logic [FINE_W-1:0] MAX = '1;

  logic [FINE_W-1:0] fine_q;
  logic dn, up;

  assign dn    = en_i && early_i && !late_i;
  assign up    = en_i && late_i && !early_i;
  assign sat_o = (dn && fine_q == '0) || (up && fine_q == MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    fine_q <= MID;
    else if (load_i)                fine_q <= MID;
    else if (dn && fine_q != '0)    fine_q <= fine_q - 1'b1;
    else if (up && fine_q != MAX)   fine_q <= fine_q + 1'b1;
  end

  assign fine_o = fine_q;
endmodule

// File: rtl/lock_detect.sv
module lock_detect #(
  parameter int TRACK_WIN = 32,
  parameter int LOCK_WINS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic early_i,
  input  logic late_i,
  input  logic sat_i,
  output logic locked_o
);
  localparam int SW = (LOCK_WINS > 1) ? $clog2(LOCK_WINS) : 1;
  localparam logic [SW-1:0] LAST = SW'(LOCK_WINS - 1);

  logic tick;
  logic seen_e_q, seen_l_q, bad_q, locked_q;
  logic [SW-1:0] streak_q;
  logic good;

  win_timer #(.WIN(TRACK_WIN)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_o (tick)
  );

  // window counts as dithering only if both directions were seen
  assign good = (seen_e_q || early_i) && (seen_l_q || late_i) && !bad_q && !sat_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_e_q <= 1'b0;
      seen_l_q <= 1'b0;
      bad_q    <= 1'b0;
      streak_q <= '0;
      locked_q <= 1'b0;
    end else if (!en_i) begin
      seen_e_q <= 1'b0;
      seen_l_q <= 1'b0;
      bad_q    <= 1'b0;
      streak_q <= '0;
      locked_q <= 1'b0;
    end else begin
      if (tick) begin
        seen_e_q <= 1'b0;
        seen_l_q <= 1'b0;
        bad_q    <= 1'b0;
      end else begin
        seen_e_q <= seen_e_q || early_i;
        seen_l_q <= seen_l_q || late_i;
        bad_q    <= bad_q || sat_i;
      end
      if (sat_i) begin
        streak_q <= '0;
        locked_q <= 1'b0;
      end else if (tick) begin
        if (!good)                 streak_q <= '0;
        else if (streak_q == LAST) locked_q <= 1'b1;
        else                       streak_q <= streak_q + 1'b1;
      end
    end
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/clk_lock_ctrl.sv
module clk_lock_ctrl #(
  parameter int CODE_W    = 6,
  parameter int FINE_W    = 8,
  parameter int CAL_WIN   = 16,
  parameter int TRACK_WIN = 32,
  parameter int LOCK_WINS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cal_mode_i,
  input  logic              freq_fast_i,
  input  logic              early_i,
  input  logic              late_i,
  output logic [CODE_W-1:0] coarse_o,
  output logic [FINE_W-1:0] fine_o,
  output logic              locked_o
);
  import clk_lock_pkg::*;

  lock_state_e state_q, state_d;
  logic cal_tick, sar_start, sar_done, fine_load, sat, trk_en;

  assign trk_en    = (state_q == ST_TRACK);
  assign sar_start = cal_mode_i && ((state_q == ST_START) || (trk_en && sat));
  assign fine_load = (state_q == ST_START) || sar_start || sar_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_START: state_d = cal_mode_i ? ST_CAL : ST_TRACK;
      ST_CAL:   if (sar_done) state_d = ST_TRACK;
      ST_TRACK: if (sat && cal_mode_i) state_d = ST_CAL;
      default:  state_d = ST_START;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_START;
    else         state_q <= state_d;
  end

  win_timer #(.WIN(CAL_WIN)) u_cal_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_CAL),
    .tick_o (cal_tick)
  );

  sar_search #(.CODE_W(CODE_W)) u_sar (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sar_start),
    .step_i  (cal_tick),
    .fast_i  (freq_fast_i),
    .code_o  (coarse_o),
    .done_o  (sar_done)
  );

  fine_track #(.FINE_W(FINE_W)) u_fine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (fine_load),
    .en_i    (trk_en),
    .early_i (early_i),
    .late_i  (late_i),
    .fine_o  (fine_o),
    .sat_o   (sat)
  );

  lock_detect #(.TRACK_WIN(TRACK_WIN), .LOCK_WINS(LOCK_WINS)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (trk_en),
    .early_i  (early_i),
    .late_i   (late_i),
    .sat_i    (sat),
    .locked_o (locked_o)
  );
endmodule

// File: rtl/clk_lock_ctrl_chk.sv
module clk_lock_ctrl_chk #(
  parameter int CODE_W = 6,
  parameter int FINE_W = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input clk_lock_pkg::lock_state_e state_i,
  input logic [CODE_W-1:0]         coarse_o,
  input logic [FINE_W-1:0]         fine_o,
  input logic                      locked_o
);
  import clk_lock_pkg::*;
  localparam logic [FINE_W-1:0] MID  = FINE_W'(1) << (FINE_W - 1);
  localparam logic [FINE_W-1:0] MAX  = '1;
  localparam logic [CODE_W-1:0] CMID = CODE_W'(1) << (CODE_W - 1);

  p_fine_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fine_o != $past(fine_o)) |->
      ({1'b0, fine_o} == {1'b0, $past(fine_o)} + 1'b1 ||
       {1'b0, fine_o} + 1'b1 == {1'b0, $past(fine_o)} ||
       fine_o == MID));

  p_cal_fine_mid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CAL) |-> (fine_o == MID));

  p_coarse_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_TRACK && $past(state_i) == ST_TRACK) |-> $stable(coarse_o));

  p_lock_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> ($past(fine_o) == '0 || $past(fine_o) == MAX));

  p_lock_in_track_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (state_i == ST_TRACK));

  p_restart_mid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CAL && $past(state_i) == ST_TRACK) |-> (coarse_o == CMID));
endmodule

bind clk_lock_ctrl clk_lock_ctrl_chk #(.CODE_W(CODE_W), .FINE_W(FINE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .state_i  (state_q),
  .coarse_o (coarse_o),
  .fine_o   (fine_o),
  .locked_o (locked_o)
);

// File: tb/clk_lock_ctrl_bench.sv
module clk_lock_ctrl_bench;
  localparam int CODE_W = 6, FINE_W = 8, CAL_WIN = 16, TRACK_WIN = 32, LOCK_WINS = 4;
  localparam int MID = 1 << (FINE_W - 1);
  localparam int FMAX = (1 << FINE_W) - 1;
  localparam int CMID = 1 << (CODE_W - 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cal_mode, freq_fast, early, late, locked;
  logic [CODE_W-1:0] coarse;
  logic [FINE_W-1:0] fine;
  int target;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // oscillator model: frequency rises with code; fast when above target code
  assign freq_fast = (int'(coarse) > target);

  clk_lock_ctrl #(.CODE_W(CODE_W), .FINE_W(FINE_W), .CAL_WIN(CAL_WIN),
                  .TRACK_WIN(TRACK_WIN), .LOCK_WINS(LOCK_WINS)) u_clk_lock_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cal_mode_i(cal_mode), .freq_fast_i(freq_fast),
    .early_i(early), .late_i(late), .coarse_o(coarse), .fine_o(fine), .locked_o(locked));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit e, bit l);
    early = e; late = l;
    @(negedge clk);
  endtask

  task automatic do_reset(bit mode);
    rst_n = 1'b0; cal_mode = mode; early = 1'b0; late = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int next_fine(int f, bit e, bit l);
    if (e && !l) return (f == 0) ? 0 : f - 1;
    if (l && !e) return (f == FMAX) ? FMAX : f + 1;
    return f;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int tlist[7];
    int exp_f;
    void'($urandom(32'd2024));
    target = 40;
    rst_n = 1'b0; cal_mode = 1'b1; early = 1'b0; late = 1'b0;
    @(negedge clk);
    check("R1 coarse", int'(coarse), CMID);
    check("R1 fine", int'(fine), MID);
    check("R1 locked", int'(locked), 0);

    // R2 / R6: calibration search over several targets
    tlist = '{0, 63, 21, 42, 0, 0, 0};
    for (int k = 4; k < 7; k++) tlist[k] = int'($urandom % 64);
    foreach (tlist[k]) begin
      target = tlist[k];
      do_reset(1'b1);
      repeat (CAL_WIN + 1) step(1'b1, 1'b0);
      check("R2 first decision", int'(coarse), (CMID > target) ? 16 : 48);
      repeat (5 * CAL_WIN) step(1'b1, 1'b0);
      check("R2 final code", int'(coarse), target);
      check("R6 fine held", int'(fine), MID);
      check("R7 not locked", int'(locked), 0);
      step(1'b1, 1'b0);
      check("R2 tracking begins", int'(fine), MID - 1);
    end

    // R9: saturation restarts calibration in mode 1
    for (int i = 0; i < 400 && fine != 0; i++) step(1'b1, 1'b0);
    check("R5 reached zero", int'(fine), 0);
    step(1'b1, 1'b0);
    check("R9 coarse restart", int'(coarse), CMID);
    check("R9 fine mid", int'(fine), MID);
    check("R8 locked low", int'(locked), 0);
    repeat (6 * CAL_WIN) step(1'b0, 1'b1);
    check("R6 fine held in restart", int'(fine), MID);
    step(1'b0, 1'b0);
    check("R9 code recovered", int'(coarse), target);

    // R3: mode 0 tracks directly
    target = 5;
    do_reset(1'b0);
    step(1'b1, 1'b0);
    check("R3 first clock idle", int'(fine), MID);
    step(1'b1, 1'b0);
    check("R3 early acts", int'(fine), MID - 1);
    check("R3 coarse mid", int'(coarse), CMID);
    exp_f = MID - 1;
    step(1'b1, 1'b1);
    check("R4 both no change", int'(fine), exp_f);

    // R7: one-sided windows never lock
    for (int i = 0; i < (LOCK_WINS + 2) * TRACK_WIN; i++) begin
      step(1'b0, (i % 4) == 0);
      exp_f = next_fine(exp_f, 1'b0, (i % 4) == 0);
      check("R4 late steps", int'(fine), exp_f);
    end
    check("R7 one-sided no lock", int'(locked), 0);
    for (int i = 0; i < (LOCK_WINS - 1) * TRACK_WIN - 1; i++) begin
      step((i % 2) == 0, (i % 2) == 1);
      exp_f = next_fine(exp_f, (i % 2) == 0, (i % 2) == 1);
    end
    check("R7 too early", int'(locked), 0);
    for (int i = 0; i < 2 * TRACK_WIN + 2; i++) begin
      step((i % 2) == 0, (i % 2) == 1);
      exp_f = next_fine(exp_f, (i % 2) == 0, (i % 2) == 1);
    end
    check("R7 locked", int'(locked), 1);
    check("R4 dither fine", int'(fine), exp_f);

    // R8 / R5 in mode 0
    for (int i = 0; i < 400 && fine != 0; i++) step(1'b1, 1'b0);
    check("R7 sticky before push", int'(locked), 1);
    step(1'b1, 1'b0);
    check("R8 push clears lock", int'(locked), 0);
    check("R5 floor", int'(fine), 0);
    check("R3 no restart", int'(coarse), CMID);
    for (int i = 0; i < 400 && fine != FMAX; i++) step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    check("R5 ceiling", int'(fine), FMAX);
    check("R10 coarse held", int'(coarse), CMID);

    // random tracking against the model
    do_reset(1'b0);
    step(1'b0, 1'b0);
    exp_f = MID;
    for (int b = 0; b < 8; b++) begin
      int bias = (b % 2 == 0) ? 80 : 20;
      for (int i = 0; i < 150; i++) begin
        bit e = ($urandom % 100) < bias;
        bit l = ($urandom % 100) >= bias;
        if (($urandom % 8) == 0) l = e;
        step(e, l);
        exp_f = next_fine(exp_f, e, l);
        check("R4 R5 random", int'(fine), exp_f);
      end
    end
    check("R10 coarse random", int'(coarse), CMID);

    finished = 1;
    summary();
    $finish;
  end
endmodule